// File: doc/BRIEF.md
# SIMD Permute and Broadcast Unit

This block rearranges the elements of 256-bit vectors. Each accepted request carries two 256-bit sources, a 4-bit operation code and an 8-bit immediate. The unit can replicate a scalar into every element of the result. It can insert a 128-bit value into either half of the result, or extract one half. It can shuffle 32-bit or 64-bit elements within each 128-bit lane, or across the whole vector. It can also build the result from the four 128-bit chunks of the two sources. For the permutes, the second source supplies one index per element. The result is registered and appears one clock after the request.

Control is a two-state machine. `ST_IDLE` means no result is presented. `ST_EMIT` means `res_valid` is high and `res_data` holds the new result. The transition `GO_EMIT` is taken on any clock where `req_valid` is high, from either state. The transition `GO_IDLE` is taken on any clock where `req_valid` is low. A stream of back-to-back requests therefore keeps the machine in `ST_EMIT`. `res_data` is loaded only on `GO_EMIT` and holds its value otherwise.

Top module: `simd_perm_unit`

## Requirements
- R1: While reset is asserted and after it is released with no request, `res_valid` is 0 and `res_data` is all zeros.
- R2: `res_valid` is 1 on the clock after each clock with `req_valid` high, and 0 otherwise. When `req_valid` is low, `res_data` keeps its previous value.
- R3: Op codes 0 to 4 replicate the low 8, 16, 32, 64 or 128 bits of `src_a` (in that order) into every element of the result.
- R4: Op 5 (insert) copies `src_a` and replaces one half with `src_b[127:0]`. `imm[0]`=0 selects bits 127:0 and `imm[0]`=1 selects bits 255:128; the other half is left as in `src_a`.
- R5: Op 6 (extract) puts bits 127:0 of `src_a` (`imm[0]`=0) or bits 255:128 (`imm[0]`=1) into result bits 127:0. Result bits 255:128 are zero.
- R6: Op 7 (in-lane 32-bit permute) sets result element i (32 bits, i=0..7) to `src_a` element 4*(i/4)+s. Here s is bits 1:0 of `src_b` element i. No element crosses the 128-bit boundary.
- R7: Op 8 (in-lane 64-bit permute) sets result element i (64 bits, i=0..3) to `src_a` element 2*(i/2)+`src_b`[64*i].
- R8: Op 9 (cross-lane 32-bit permute) sets result element i to `src_a` element k. Here k is bits 2:0 of `src_b` 32-bit element i.
- R9: Op 10 (cross-lane 64-bit permute) sets result element i to `src_a` 64-bit element k. Here k is bits 1:0 of `src_b` 64-bit element i.
- R10: Op 11 (chunk select) fills result bits 127:0 from the chunk chosen by `imm[1:0]`, and bits 255:128 from the chunk chosen by `imm[5:4]`. The code is 0=`src_a` low, 1=`src_a` high, 2=`src_b` low, 3=`src_b` high.
- R11: In op 11, `imm[3]`=1 forces result bits 127:0 to zero and `imm[7]`=1 forces bits 255:128 to zero. Either bit overrides that half's chunk code.
- R12: Op codes 12 to 15 produce an all-zero result, still with `res_valid` pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this clock |
| op | input | 4 | Operation code |
| imm | input | 8 | Immediate control byte |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector or per-element index vector |
| res_valid | output | 1 | Result presented this clock |
| res_data | output | 256 | Registered result |

## Verification
Every result is due exactly one rising edge after the request that produced it, in every mode. The bench drives a request after a falling edge. It computes the expected value at the next rising edge and compares both outputs at the falling edge after that, once per clock. The idle clocks between bursts are compared the same way, with `res_valid` expected low and `res_data` expected unchanged even though the source inputs keep moving.

// File: rtl/spu_pkg.sv
package spu_pkg;
    localparam int VEC_W  = 256;
    localparam int LANE_W = 128;
    localparam int BASE_W = 8;

    typedef enum logic [3:0] {
        OP_BC8    = 4'd0,
        OP_BC16   = 4'd1,
        OP_BC32   = 4'd2,
        OP_BC64   = 4'd3,
        OP_BC128  = 4'd4,
        OP_INS    = 4'd5,
        OP_EXT    = 4'd6,
        OP_LP32   = 4'd7,
        OP_LP64   = 4'd8,
        OP_XP32   = 4'd9,
        OP_XP64   = 4'd10,
        OP_CHUNK  = 4'd11,
        OP_RSV12  = 4'd12,
        OP_RSV13  = 4'd13,
        OP_RSV14  = 4'd14,
        OP_RSV15  = 4'd15
    } op_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } state_e;
endpackage

// File: rtl/spu_bcast.sv
module spu_bcast #(
    parameter int VEC_W  = spu_pkg::VEC_W,
    parameter int LANE_W = spu_pkg::LANE_W,
    parameter int BASE_W = spu_pkg::BASE_W
) (
    input  logic [VEC_W-1:0] src,
    input  logic [2:0]       size_sel,
    output logic [VEC_W-1:0] res
);
    localparam int NSZ = $clog2(LANE_W / BASE_W) + 1;

    logic [VEC_W-1:0] rep [NSZ];

    genvar g;
    generate
        for (g = 0; g < NSZ; g++) begin : g_size
            localparam int W = BASE_W << g;
            assign rep[g] = {(VEC_W / W){src[W-1:0]}};
        end
    endgenerate

    always_comb begin
        res = '0;
        for (int s = 0; s < NSZ; s++) begin
            if (int'(size_sel) == s) res = rep[s];
        end
    end
endmodule

// File: rtl/spu_lane_perm.sv
module spu_lane_perm #(
    parameter int VEC_W  = spu_pkg::VEC_W,
    parameter int LANE_W = spu_pkg::LANE_W,
    parameter int EW     = 32
) (
    input  logic [VEC_W-1:0] src,
    input  logic [VEC_W-1:0] sel,
    output logic [VEC_W-1:0] res
);
    localparam int NE = VEC_W / EW;
    localparam int NL = LANE_W / EW;
    localparam int IW = (NL > 1) ? $clog2(NL) : 1;

    genvar i;
    generate
        for (i = 0; i < NE; i++) begin : g_elem
            localparam int LBASE = (i / NL) * NL;
            logic [IW-1:0] idx;
            assign idx = sel[i*EW +: IW];
            assign res[i*EW +: EW] = src[(LBASE + int'(idx)) * EW +: EW];
        end
    endgenerate
endmodule

// File: rtl/spu_cross_perm.sv
module spu_cross_perm #(
    parameter int VEC_W = spu_pkg::VEC_W,
    parameter int EW    = 32
) (
    input  logic [VEC_W-1:0] src,
    input  logic [VEC_W-1:0] sel,
    output logic [VEC_W-1:0] res
);
    localparam int NE = VEC_W / EW;
    localparam int IW = $clog2(NE);

    genvar i;
    generate
        for (i = 0; i < NE; i++) begin : g_elem
            logic [IW-1:0] idx;
            assign idx = sel[i*EW +: IW];
            assign res[i*EW +: EW] = src[int'(idx) * EW +: EW];
        end
    endgenerate
endmodule

// File: rtl/spu_chunk_sel.sv
module spu_chunk_sel #(
    parameter int VEC_W  = spu_pkg::VEC_W,
    parameter int LANE_W = spu_pkg::LANE_W
) (
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [7:0]       ctl,
    output logic [VEC_W-1:0] res
);
    localparam int NH = VEC_W / LANE_W;
    localparam int NC = 2 * NH;
    localparam int CW = $clog2(NC);

    logic [LANE_W-1:0] chunk [NC];

    genvar c, h;
    generate
        for (c = 0; c < NH; c++) begin : g_chunk
            assign chunk[c]      = src_a[c*LANE_W +: LANE_W];
            assign chunk[NH + c] = src_b[c*LANE_W +: LANE_W];
        end
        for (h = 0; h < NH; h++) begin : g_half
            logic [CW-1:0] code;
            logic          kill;
            assign code = ctl[(4*h) % 8 +: CW];
            assign kill = ctl[(4*h + 3) % 8];
            assign res[h*LANE_W +: LANE_W] = kill ? '0 : chunk[code];
        end
    endgenerate
endmodule

// File: rtl/simd_perm_unit.sv
module simd_perm_unit
    import spu_pkg::*;
#(
    parameter int DATA_W = spu_pkg::VEC_W,
    parameter int HALF_W = spu_pkg::LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        op,
    input  logic [7:0]        imm,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);
    state_e state_q, state_d;

    logic [DATA_W-1:0] bc_res, lp32_res, lp64_res, xp32_res, xp64_res, ch_res;
    logic [DATA_W-1:0] result;
    logic [2:0]        bc_size;

    assign bc_size = op[2:0];

    spu_bcast #(.VEC_W(DATA_W), .LANE_W(HALF_W), .BASE_W(BASE_W)) u_bcast (
        .src(src_a), .size_sel(bc_size), .res(bc_res)
    );
    spu_lane_perm #(.VEC_W(DATA_W), .LANE_W(HALF_W), .EW(32)) u_lp32 (
        .src(src_a), .sel(src_b), .res(lp32_res)
    );
    spu_lane_perm #(.VEC_W(DATA_W), .LANE_W(HALF_W), .EW(64)) u_lp64 (
        .src(src_a), .sel(src_b), .res(lp64_res)
    );
    spu_cross_perm #(.VEC_W(DATA_W), .EW(32)) u_xp32 (
        .src(src_a), .sel(src_b), .res(xp32_res)
    );
    spu_cross_perm #(.VEC_W(DATA_W), .EW(64)) u_xp64 (
        .src(src_a), .sel(src_b), .res(xp64_res)
    );
    spu_chunk_sel #(.VEC_W(DATA_W), .LANE_W(HALF_W)) u_chunk (
        .src_a(src_a), .src_b(src_b), .ctl(imm), .res(ch_res)
    );

    // result mux
    always_comb begin
        result = '0;
        unique case (op_e'(op))
            OP_BC8, OP_BC16, OP_BC32, OP_BC64, OP_BC128: result = bc_res;
            OP_INS: begin
                result = src_a;
                if (imm[0]) result[DATA_W-1:HALF_W] = src_b[HALF_W-1:0];
                else        result[HALF_W-1:0]      = src_b[HALF_W-1:0];
            end
            OP_EXT: result[HALF_W-1:0] = imm[0] ? src_a[DATA_W-1:HALF_W]
                                                : src_a[HALF_W-1:0];
            OP_LP32:  result = lp32_res;
            OP_LP64:  result = lp64_res;
            OP_XP32:  result = xp32_res;
            OP_XP64:  result = xp64_res;
            OP_CHUNK: result = ch_res;
            OP_RSV12, OP_RSV13, OP_RSV14, OP_RSV15: result = '0;
            default:  result = '0;
        endcase
    end

    // next state: GO_EMIT on request, GO_IDLE otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = req_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n)         res_data <= '0;
        else if (req_valid) res_data <= result;
    end

    assign res_valid = (state_q == ST_EMIT);
endmodule

// File: rtl/spu_checker.sv
module spu_checker #(
    parameter int DATA_W = spu_pkg::VEC_W,
    parameter int HALF_W = spu_pkg::LANE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [3:0]        op,
    input logic [7:0]        imm,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);
    assert_data_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(res_data));
    assert_bcast8_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == 4'd0) |=> res_data == {(DATA_W/8){$past(src_a[7:0])}});
    assert_insert_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == 4'd5 && !imm[0]) |=>
            res_data[DATA_W-1:HALF_W] == $past(src_a[DATA_W-1:HALF_W]));
    assert_extract_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == 4'd6) |=> res_data[DATA_W-1:HALF_W] == '0);
    assert_chunk_kill_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == 4'd11 && imm[3] && imm[7]) |=> res_data == '0);
    assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op[3:2] == 2'b11) |=> res_data == '0);
endmodule

bind simd_perm_unit spu_checker #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_spu_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op), .imm(imm),
    .src_a(src_a), .src_b(src_b), .res_valid(res_valid), .res_data(res_data)
);

// File: tb/simd_perm_unit_test.sv
module simd_perm_unit_test;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [3:0]   op = '0;
    logic [7:0]   imm = '0;
    logic [255:0] src_a = '0;
    logic [255:0] src_b = '0;
    logic         res_valid;
    logic [255:0] res_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic         exp_valid = 1'b0;
    logic [255:0] exp_data = '0;
    string        exp_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_perm_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op), .imm(imm),
        .src_a(src_a), .src_b(src_b), .res_valid(res_valid), .res_data(res_data)
    );

    function automatic logic [255:0] model(input int o, input logic [7:0] im,
                                           input logic [255:0] a, input logic [255:0] b);
        logic [255:0] r = '0;
        logic [127:0] ch [4];
        int w, k;
        ch[0] = a[127:0]; ch[1] = a[255:128]; ch[2] = b[127:0]; ch[3] = b[255:128];
        case (o)
            0, 1, 2, 3, 4: begin
                w = 8 << o;
                for (int j = 0; j < 256; j++) r[j] = a[j % w];
            end
            5: begin
                r = a;
                if (im[0]) r[255:128] = b[127:0];
                else       r[127:0]   = b[127:0];
            end
            6: r[127:0] = im[0] ? a[255:128] : a[127:0];
            7: for (int i = 0; i < 8; i++) begin
                   k = (i / 4) * 4 + int'(b[32*i +: 2]);
                   r[32*i +: 32] = a[32*k +: 32];
               end
            8: for (int i = 0; i < 4; i++) begin
                   k = (i / 2) * 2 + int'(b[64*i]);
                   r[64*i +: 64] = a[64*k +: 64];
               end
            9: for (int i = 0; i < 8; i++) begin
                   k = int'(b[32*i +: 3]);
                   r[32*i +: 32] = a[32*k +: 32];
               end
            10: for (int i = 0; i < 4; i++) begin
                   k = int'(b[64*i +: 2]);
                   r[64*i +: 64] = a[64*k +: 64];
               end
            11: begin
                r[127:0]   = im[3] ? 128'd0 : ch[im[1:0]];
                r[255:128] = im[7] ? 128'd0 : ch[im[5:4]];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input int o, input logic [7:0] im);
        case (o)
            0, 1, 2, 3, 4: return "R3";
            5: return "R4";
            6: return "R5";
            7: return "R6";
            8: return "R7";
            9: return "R8";
            10: return "R9";
            11: return (im[3] || im[7]) ? "R11" : "R10";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    task automatic compare();
        checks++;
        if (res_valid !== exp_valid) begin
            errors++;
            $display("FAIL R2 res_valid actual=%0b expected=%0b", res_valid, exp_valid);
        end
        checks++;
        if (res_data !== exp_data) begin
            errors++;
            $display("FAIL %s res_data actual=%h expected=%h", exp_tag, res_data, exp_data);
        end
    endtask

    // drive after a falling edge, model at the rising edge, compare at the next falling edge
    task automatic step(input bit v, input int o, input logic [7:0] im,
                        input logic [255:0] a, input logic [255:0] b);
        req_valid = v; op = 4'(o); imm = im; src_a = a; src_b = b;
        @(posedge clk);
        exp_valid = v;
        if (v) begin
            exp_data = model(o, im, a, b);
            exp_tag  = tag_of(o, im);
        end else begin
            exp_tag = "R2";
        end
        @(negedge clk);
        compare();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        exp_tag = "R1";
        compare();                       // R1 during reset
        rst_n = 1'b1;
        step(1'b0, 0, 8'h00, rnd256(), rnd256());   // R1 after release, nothing requested
        // every op, several patterns, back-to-back
        for (int o = 0; o < 16; o++) begin
            for (int n = 0; n < 6; n++) begin
                step(1'b1, o, 8'($urandom), rnd256(), rnd256());
            end
            step(1'b0, 0, 8'hFF, rnd256(), rnd256());   // R2 hold while inputs move
        end
        // R4/R5 both halves explicitly
        step(1'b1, 5, 8'h00, rnd256(), rnd256());
        step(1'b1, 5, 8'h01, rnd256(), rnd256());
        step(1'b1, 6, 8'h00, rnd256(), rnd256());
        step(1'b1, 6, 8'h01, rnd256(), rnd256());
        // R10 all code pairs, R11 kill bits
        for (int lo = 0; lo < 4; lo++) begin
            for (int hi = 0; hi < 4; hi++) begin
                step(1'b1, 11, 8'((hi << 4) | lo), rnd256(), rnd256());
            end
        end
        step(1'b1, 11, 8'h08, rnd256(), rnd256());
        step(1'b1, 11, 8'h80, rnd256(), rnd256());
        step(1'b1, 11, 8'h88, rnd256(), rnd256());
        // R6..R9 extreme index vectors
        step(1'b1, 7, 8'h00, rnd256(), {8{32'h3}});
        step(1'b1, 8, 8'h00, rnd256(), {4{64'h1}});
        step(1'b1, 9, 8'h00, rnd256(), {8{32'h7}});
        step(1'b1, 10, 8'h00, rnd256(), {4{64'h3}});
        // R2 isolated pulses separated by idle
        for (int n = 0; n < 10; n++) begin
            step(1'b1, n % 12, 8'($urandom), rnd256(), rnd256());
            step(1'b0, 0, 8'($urandom), rnd256(), rnd256());
            step(1'b0, 0, 8'($urandom), rnd256(), rnd256());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule